// File: doc/BRIEF.md
# Inter-Core Mailbox Doorbell Unit

This unit gives four processor cores a way to ring each other. Each core owns four 32-bit mailbox words. Any requester can OR bits into a core's mailbox through a set window. The owning core reads its mailbox and retires the bits it has handled through a clear window that lives in a separate address range over the same storage. Software gives each doorbell a number k and encodes it as the single bit 1<<k. The receiver services the lowest pending bit first and clears only that bit.

Mailbox 0 of each core drives that core's interrupt line. The line is high while the mailbox holds any set bit and the core's enable bit is on. Mailboxes 1 to 3 are plain storage with the same set and clear behaviour, and they never interrupt.

The register bus has two independent ports that share one address map, so two requesters can act in the same cycle. Byte address map, 8 bits wide:
- Enable register of core n: 0x00+4n.
- Set window for core n, mailbox m: 0x40+16n+4m.
- Clear window for core n, mailbox m: 0x80+16n+4m.
- Everything else is unmapped.

Top module: `mbx_doorbell`

## Requirements
- R1: After reset every mailbox word reads 0, every enable reads 0 and all interrupt lines are low.
- R2: A write to the set window at 0x40+16n+4m ORs the write data into mailbox m of core n, and leaves already-set bits unchanged.
- R3: A read strobe returns data on that port's read bus in the following cycle. Clear-window reads (0x80+16n+4m) return the mailbox word as it stood before that edge. Set-window and unmapped reads return 0. The read bus is 0 in any cycle that does not follow a read strobe.
- R4: A write to the clear window clears exactly the bits that are 1 in the write data. Clearing the lowest set bit one at a time leaves the remaining bits intact.
- R5: The enable register of core n at 0x00+4n stores write-data bit 0 and reads back as {31'b0, enable}. Other data bits are ignored.
- R6: irq[n] is high exactly when core n's enable is 1 and its mailbox 0 is non-zero. Mailboxes 1 to 3 never affect irq[n].
- R7: When a set and a clear hit the same bit in the same cycle (on different ports), the bit ends up set. Sets from both ports in one cycle are ORed together.
- R8: When both ports write the same enable register in one cycle, port 1's value is kept.
- R9: A mailbox not addressed by a write keeps its value. An access whose two low address bits are non-zero is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | NPORT | Write strobe per port |
| bus_rd | input | NPORT | Read strobe per port |
| bus_addr | input | NPORT*AW | Byte address per port |
| bus_wdata | input | NPORT*DW | Write data per port |
| bus_rdata | output | NPORT*DW | Registered read data per port |
| mbx_irq | output | NCORE | Mailbox-0 interrupt per core |

## Verification
The doorbell path is driven with several patterns:
- Repeated ORs into one word show that set accumulates rather than overwrites.
- A sparse three-bit pattern is retired lowest bit first. This separates clear-exactly-these-bits from clear-all, and shows when the interrupt falls.
- Dual-port cycles pit a set against a clear on the same bit, and two sets against each other. These expose the wrong priority or a lost OR.
- Conflicting enable writes check the port-1 priority.

Neighbouring mailbox words, set-window reads, unmapped and misaligned addresses are read back to show that nothing leaks across cores or mailboxes.

// File: rtl/mbx_pkg.sv
// Package: shared sizes and the decoded-access type for the doorbell unit.
// Assumes the fixed address map given in the brief (four cores, four mailboxes).
package mbx_pkg;
    localparam int NCORE = 4;
    localparam int NMBOX = 4;
    localparam int CW    = $clog2(NCORE);
    localparam int MW    = $clog2(NMBOX);

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_EN   = 2'd1,
        RG_SET  = 2'd2,
        RG_CLR  = 2'd3
    } region_e;

    typedef struct packed {
        region_e         region;
        logic [CW-1:0]   core;
        logic [MW-1:0]   mbox;
    } dec_t;
endpackage

// File: rtl/mbx_decode.sv
// Module: address decoder for one bus port.
// Maps a byte address onto region, core and mailbox index. Misaligned
// addresses and the top quarter of the map decode as RG_NONE.
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr,
    output dec_t          dec
);
    // Split the address into its fields and classify the region.
    always_comb begin
        dec.core   = addr[5:4];
        dec.mbox   = addr[3:2];
        dec.region = RG_NONE;
        if (addr[1:0] == 2'b00 && addr[AW-1:8] == '0) begin
            unique case (addr[7:6])
                2'b00: begin
                    dec.core = addr[3:2];
                    if (addr[5:4] == 2'b00) dec.region = RG_EN;
                end
                2'b01:   dec.region = RG_SET;
                2'b10:   dec.region = RG_CLR;
                default: dec.region = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/mbx_cell.sv
// Module: one 32-bit mailbox word with set and clear masks.
// Assumes the masks are already merged across ports. Set has priority over clear.
module mbx_cell #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] set_mask,
    input  logic [DW-1:0] clr_mask,
    output logic [DW-1:0] q
);
    // Update the word: drop the cleared bits, then OR in the set bits.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr_mask) | set_mask;
    end

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> q == '0); // R1
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (q & $past(set_mask)) == $past(set_mask)); // R7
    AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (q & $past(clr_mask & ~set_mask)) == '0); // R4
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(set_mask == '0 && clr_mask == '0)) |-> q == $past(q)); // R9
endmodule

// File: rtl/mbx_doorbell.sv
// Module: inter-core mailbox doorbell unit, the top level.
// It has NPORT register ports that share one map and a word of storage per core
// and mailbox, and it raises one interrupt per core from mailbox 0. Assumes
// the map fixes four cores and four mailboxes, and that reads answer one
// cycle after the strobe.
module mbx_doorbell
    import mbx_pkg::*;
#(
    parameter int NPORT = 2,
    parameter int DW    = 32,
    parameter int AW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPORT-1:0]    bus_wr,
    input  logic [NPORT-1:0]    bus_rd,
    input  logic [NPORT*AW-1:0] bus_addr,
    input  logic [NPORT*DW-1:0] bus_wdata,
    output logic [NPORT*DW-1:0] bus_rdata,
    output logic [NCORE-1:0]    mbx_irq
);
    dec_t          dec      [NPORT];
    logic [DW-1:0] set_m    [NCORE][NMBOX];
    logic [DW-1:0] clr_m    [NCORE][NMBOX];
    logic [DW-1:0] mbox_q   [NCORE][NMBOX];
    logic [NCORE-1:0] en_q;
    logic [NCORE-1:0] en_hit;
    logic [DW-1:0] rdata_q  [NPORT];

    for (genvar p = 0; p < NPORT; p++) begin : g_dec
        mbx_decode #(.AW(AW)) u_dec (.addr(bus_addr[p*AW +: AW]), .dec(dec[p]));
    end

    // Merge the set and clear writes of all ports into per-word masks.
    always_comb begin
        for (int c = 0; c < NCORE; c++) begin
            for (int m = 0; m < NMBOX; m++) begin
                set_m[c][m] = '0;
                clr_m[c][m] = '0;
                for (int p = 0; p < NPORT; p++) begin
                    if (bus_wr[p] && dec[p].core == CW'(c) && dec[p].mbox == MW'(m)) begin
                        if (dec[p].region == RG_SET) set_m[c][m] |= bus_wdata[p*DW +: DW];
                        if (dec[p].region == RG_CLR) clr_m[c][m] |= bus_wdata[p*DW +: DW];
                    end
                end
            end
        end
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        for (genvar m = 0; m < NMBOX; m++) begin : g_mbox
            mbx_cell #(.DW(DW)) u_cell (
                .clk(clk), .rst_n(rst_n),
                .set_mask(set_m[c][m]), .clr_mask(clr_m[c][m]),
                .q(mbox_q[c][m])
            );
        end
        assign mbx_irq[c] = en_q[c] && (mbox_q[c][0] != '0);
    end

    // Flag the cores whose enable register any port writes this cycle.
    always_comb begin
        en_hit = '0;
        for (int p = 0; p < NPORT; p++)
            if (bus_wr[p] && dec[p].region == RG_EN) en_hit[dec[p].core] = 1'b1;
    end

    // Enable registers; the highest-numbered writing port is applied last and wins.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else begin
            for (int p = 0; p < NPORT; p++)
                if (bus_wr[p] && dec[p].region == RG_EN)
                    en_q[dec[p].core] <= bus_wdata[p*DW];
        end
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_en_chk
        AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(en_hit[c])) |-> en_q[c] == $past(en_q[c])); // R5
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        // Registered read mux for one port; quiet (zero) when no read was asked.
        always_ff @(posedge clk) begin
            if (!rst_n || !bus_rd[p]) rdata_q[p] <= '0;
            else begin
                unique case (dec[p].region)
                    RG_EN:   rdata_q[p] <= DW'(en_q[dec[p].core]);
                    RG_CLR:  rdata_q[p] <= mbox_q[dec[p].core][dec[p].mbox];
                    default: rdata_q[p] <= '0;
                endcase
            end
        end
        assign bus_rdata[p*DW +: DW] = rdata_q[p];

        AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(bus_rd[p]) |-> bus_rdata[p*DW +: DW] == '0); // R3
    end
endmodule

// File: tb/mbx_doorbell_test.sv
// Bench: directed tests for the doorbell unit; each task checks its own results.
module mbx_doorbell_test;
    localparam int DW = 32, AW = 8, NP = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NP-1:0]    wr = '0, rd = '0;
    logic [NP*AW-1:0] addr = '0;
    logic [NP*DW-1:0] wdata = '0;
    logic [NP*DW-1:0] rdata;
    logic [3:0]       irq;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mbx_doorbell #(.NPORT(NP), .DW(DW), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .mbx_irq(irq)
    );

    function automatic logic [7:0] a_en(int n);           return 8'(4*n); endfunction
    function automatic logic [7:0] a_set(int n, int m);   return 8'(8'h40 + 16*n + 4*m); endfunction
    function automatic logic [7:0] a_clr(int n, int m);   return 8'(8'h80 + 16*n + 4*m); endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write cycle on two ports (w0/w1 pick which ports are active).
    task automatic dual(bit w0, logic [7:0] a0, logic [31:0] d0,
                        bit w1, logic [7:0] a1, logic [31:0] d1);
        wr = {w1, w0}; addr = {a1, a0}; wdata = {d1, d0};
        @(posedge clk); @(negedge clk);
        wr = '0;
    endtask

    task automatic write(logic [7:0] a, logic [31:0] d);
        dual(1'b1, a, d, 1'b0, 8'h0, 32'h0);
    endtask

    task automatic read(int p, logic [7:0] a, output logic [31:0] v);
        rd[p] = 1'b1; addr[p*AW +: AW] = a;
        @(posedge clk); @(negedge clk);
        rd = '0;
        v = rdata[p*DW +: DW];
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check(irq == 4'h0, "R1 irq after reset", 32'(irq), 32'h0);
        for (int n = 0; n < 4; n++) begin
            read(0, a_clr(n, 0), v); check(v == 0, "R1 mailbox0 reset", v, 0);
            read(1, a_en(n), v);     check(v == 0, "R1 enable reset", v, 0);
        end
        read(0, a_clr(2, 3), v); check(v == 0, "R1 mailbox3 reset", v, 0);
    endtask

    task automatic t_set_or();
        logic [31:0] v;
        write(a_set(1, 0), 32'h5);
        write(a_set(1, 0), 32'h30);
        write(a_set(1, 0), 32'h1);
        read(0, a_clr(1, 0), v); check(v == 32'h35, "R2 set ORs", v, 32'h35);
        check(irq[1] == 1'b0, "R6 no irq while disabled", 32'(irq), 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        write(a_en(1), 32'hFFFF_FFFE);
        read(1, a_en(1), v); check(v == 0, "R5 only bit0 stored", v, 0);
        write(a_en(1), 32'hFFFF_FFFF);
        read(1, a_en(1), v); check(v == 1, "R5 enable readback", v, 1);
        check(irq == 4'b0010, "R6 irq raised", 32'(irq), 32'h2);
        write(a_clr(1, 0), 32'hFFFF_FFFF);
        check(irq == 4'b0000, "R6 irq drops on empty", 32'(irq), 32'h0);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        write(a_en(2), 32'h1);
        write(a_set(2, 3), 32'hF0F0);
        check(irq[2] == 1'b0, "R6 mailbox3 no irq", 32'(irq), 32'h0);
        write(a_clr(2, 3), 32'h00F0);
        read(0, a_clr(2, 3), v); check(v == 32'hF000, "R4 clear exact bits", v, 32'hF000);
        write(a_clr(2, 3), 32'hF000);
        write(a_en(2), 32'h0);
    endtask

    task automatic t_service();
        logic [31:0] v, exp, low;
        write(a_en(3), 32'h1);
        write(a_set(3, 0), 32'h284);
        exp = 32'h284;
        while (exp != 0) begin
            read(1, a_clr(3, 0), v);
            check(irq[3] == 1'b1, "R6 irq while pending", 32'(irq), 32'h8);
            low = v & (~v + 32'd1);
            write(a_clr(3, 0), low);
            exp = exp & ~(exp & (~exp + 32'd1));
            read(1, a_clr(3, 0), v);
            check(v == exp, "R4 lowest-first service", v, exp);
        end
        check(irq[3] == 1'b0, "R6 irq drops after service", 32'(irq), 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        write(a_set(0, 0), 32'h3);
        dual(1'b1, a_set(0, 0), 32'h10, 1'b1, a_clr(0, 0), 32'hFFFF);
        read(0, a_clr(0, 0), v); check(v == 32'h10, "R7 set beats clear", v, 32'h10);
        dual(1'b1, a_clr(0, 0), 32'h10, 1'b1, a_set(0, 0), 32'h10);
        read(1, a_clr(0, 0), v); check(v == 32'h10, "R7 set beats clear swapped", v, 32'h10);
        dual(1'b1, a_set(0, 0), 32'h100, 1'b1, a_set(0, 0), 32'h2000);
        read(0, a_clr(0, 0), v); check(v == 32'h2110, "R7 dual sets OR", v, 32'h2110);
    endtask

    task automatic t_en_conflict();
        logic [31:0] v;
        dual(1'b1, a_en(0), 32'h0, 1'b1, a_en(0), 32'h1);
        read(0, a_en(0), v); check(v == 1, "R8 port1 wins (1)", v, 1);
        dual(1'b1, a_en(0), 32'h1, 1'b1, a_en(0), 32'h0);
        read(0, a_en(0), v); check(v == 0, "R8 port1 wins (0)", v, 0);
    endtask

    task automatic t_isolation();
        logic [31:0] v;
        read(0, a_clr(0, 1), v); check(v == 0, "R9 neighbour untouched", v, 0);
        read(1, a_clr(1, 0), v); check(v == 0, "R9 other core untouched", v, 0);
        read(0, a_set(0, 0), v); check(v == 0, "R3 set window reads 0", v, 0);
        read(0, 8'hC0, v);       check(v == 0, "R3 unmapped reads 0", v, 0);
        write(a_set(1, 2) | 8'h1, 32'hFF);
        read(0, a_clr(1, 2), v); check(v == 0, "R9 misaligned ignored", v, 0);
        write(a_set(1, 2), 32'h7);
        read(0, a_clr(1, 2), v); check(v == 32'h7, "R3 clear window reads", v, 32'h7);
        @(negedge clk);
        check(rdata == '0, "R3 rdata quiet without read", rdata[31:0], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_or();
        t_enable();
        t_clear();
        t_service();
        t_collide();
        t_en_conflict();
        t_isolation();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule